// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupts

This block is a memory-mapped general-purpose I/O controller. Its address map has room for 96 pins, and 70 of them are built. The pins are split into banks of 32. Every per-pin feature (output enable, pad value, interrupt enable, interrupt polarity and interrupt type) takes a run of consecutive 32-bit words, one word per bank. Software reaches these words through a simple register port. The port has a request strobe, a write flag, an address, write data, registered read data and a ready pulse that comes one cycle after each request.

Pin inputs pass through a two-flop synchroniser. Each pin then feeds a detector that watches for a level or an edge of the chosen sense. A detected event sets a sticky per-pin status bit. Software clears a status bit by writing a one to it. A single interrupt line is high whenever any status bit whose enable bit is also set is pending. Two further words, a swap word and a control word, are plain read/write storage.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: A pin p sits in the word at feature offset + 4*(p/32), at bit p mod 32. The feature offsets are: swap 0x000, control 0x004, output enable 0x014, pad value 0x024, interrupt enable 0x044, polarity 0x104, type 0x114, status 0x124.
- R2: After reset every stored word is zero and the interrupt output is low. This covers enable, type, polarity, output enable, pad value, status, swap and control.
- R3: A request is answered by a ready pulse one cycle later. Read data is valid while ready is high. A read of any address outside the map returns zero.
- R4: An output-enable bit of 1 drives pin_oe high for that pin. A bit of 0 makes the pin an input.
- R5: The pad-value word drives pin_out and reads back the value that was written.
- R6: Bits for pins 70 to 95 (bank 2, bits 6 to 31) read as zero and ignore writes.
- R7: A change on pin_in first shows in the status bit at the third rising clock edge after it, because of the two synchroniser stages.
- R8: Type bit 1 selects edge mode. Polarity 0 then means a rising edge and polarity 1 a falling edge. An edge sets the status bit, and the bit stays set after the pin returns until software clears it.
- R9: Type bit 0 selects level mode. Polarity 0 means active high and polarity 1 active low. The status bit is set again on every cycle the active level is present, so a clear has no effect while that level lasts.
- R10: Writing a 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R11: irq_out is the OR over all pins of status AND enable. Status bits still record events while their enable bit is 0.
- R12: The swap and control words store any 32-bit value and read it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Register request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | One-cycle acknowledge of a request |
| pin_in | input | 70 | Pad input values |
| pin_out | output | 70 | Pad drive values |
| pin_oe | output | 70 | Pad output enables |
| irq_out | output | 1 | Combined interrupt |

## Verification
The bench holds a level-mode pin at its active level while writing a clear. A design that let the clear win would show the status bit drop to zero. It also checks that an edge-mode bit survives the pin going back and survives a write of zero, so a detector that lost stickiness or cleared on any write would be caught. The bench times the first status appearance to the exact cycle, which exposes a synchroniser with too few or too many stages. It also writes all ones to the partly built bank, which exposes decode that stores or returns bits for missing pins.

// File: rtl/gpio_pkg.sv
// Package: shared constants for the banked GPIO controller.
// Assumes 32-bit banks and byte addressing with one word per bank.
package gpio_pkg;
    localparam int BANK_W   = 32;
    localparam int OFS_SWAP = 'h000;
    localparam int OFS_CTRL = 'h004;
    localparam int OFS_OE   = 'h014;
    localparam int OFS_DRV  = 'h024;
    localparam int OFS_IEN  = 'h044;
    localparam int OFS_POL  = 'h104;
    localparam int OFS_TYP  = 'h114;
    localparam int OFS_STS  = 'h124;
endpackage

// File: rtl/gpio_sync.sv
// Module: two-flop synchroniser, one chain per pin.
// Assumes the inputs are asynchronous to clk; the output lags the input by two edges.
module gpio_sync #(
    parameter int W = 70
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Move the pad values through two register stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

    // R7: the output equals the input from two cycles earlier.
    a_r7_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (q == $past(d, 2)));
endmodule

// File: rtl/gpio_detect.sv
// Module: per-pin event detector and sticky status register.
// Assumes lvl is already synchronised. In edge mode lvl is compared with its value one
// cycle earlier; in level mode the active level is reported every cycle.
// On the same edge, a new event takes priority over a clear request.
module gpio_detect #(
    parameter int W = 70
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] typ,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] clr,
    output logic [W-1:0] sts
);
    logic [W-1:0] prev;
    logic [W-1:0] evt;

    // Per-pin event: edge of the chosen sense, or the active level.
    for (genvar i = 0; i < W; i++) begin : g_pin
        always_comb begin
            if (typ[i])
                evt[i] = pol[i] ? (prev[i] & ~lvl[i]) : (lvl[i] & ~prev[i]);
            else
                evt[i] = lvl[i] ^ pol[i];
        end
    end

    // Remember the last level and update the sticky status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= '0;
            sts  <= '0;
        end else begin
            prev <= lvl;
            sts  <= (sts & ~clr) | evt;
        end
    end

    // R8/R10: a set bit stays set unless a clear was requested.
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(sts) & ~$past(clr) & ~sts) == '0));
    // R9/R8: a bit only becomes set after a detected event.
    a_r9_set_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts & ~$past(sts) & ~$past(evt)) == '0));
endmodule

// File: rtl/gpio_regs.sv
// Module: register file with address decode, write-one-to-clear requests and read mux.
// Assumes one word per 32-pin bank; bits for pins at or above W never exist.
// Read data and ready are registered.
module gpio_regs #(
    parameter int W      = 70,
    parameter int ADDR_W = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [gpio_pkg::BANK_W-1:0] wdata,
    input  logic [W-1:0]              sts,
    output logic [W-1:0]              oe,
    output logic [W-1:0]              drv,
    output logic [W-1:0]              ien,
    output logic [W-1:0]              pol,
    output logic [W-1:0]              typ,
    output logic [W-1:0]              clr,
    output logic [gpio_pkg::BANK_W-1:0] rdata,
    output logic                      ready
);
    import gpio_pkg::*;

    logic [BANK_W-1:0] swap_q, ctrl_q, rd_val;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int base, input int p);
        return a == ADDR_W'(base + 4 * (p / BANK_W));
    endfunction

    // Store writes into the word that holds each pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swap_q <= '0; ctrl_q <= '0;
            oe <= '0; drv <= '0; ien <= '0; pol <= '0; typ <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_W'(OFS_SWAP)) swap_q <= wdata;
            if (addr == ADDR_W'(OFS_CTRL)) ctrl_q <= wdata;
            for (int p = 0; p < W; p++) begin
                if (hit(addr, OFS_OE,  p)) oe[p]  <= wdata[p % BANK_W];
                if (hit(addr, OFS_DRV, p)) drv[p] <= wdata[p % BANK_W];
                if (hit(addr, OFS_IEN, p)) ien[p] <= wdata[p % BANK_W];
                if (hit(addr, OFS_POL, p)) pol[p] <= wdata[p % BANK_W];
                if (hit(addr, OFS_TYP, p)) typ[p] <= wdata[p % BANK_W];
            end
        end
    end

    // Build the per-pin clear requests from writes to the status words.
    always_comb begin
        for (int p = 0; p < W; p++)
            clr[p] = wr_en && hit(addr, OFS_STS, p) && wdata[p % BANK_W];
    end

    // Select the read value; unmapped addresses and missing pins give zero.
    always_comb begin
        rd_val = '0;
        if (addr == ADDR_W'(OFS_SWAP)) rd_val = swap_q;
        if (addr == ADDR_W'(OFS_CTRL)) rd_val = ctrl_q;
        for (int p = 0; p < W; p++) begin
            if (hit(addr, OFS_OE,  p)) rd_val[p % BANK_W] = oe[p];
            if (hit(addr, OFS_DRV, p)) rd_val[p % BANK_W] = drv[p];
            if (hit(addr, OFS_IEN, p)) rd_val[p % BANK_W] = ien[p];
            if (hit(addr, OFS_POL, p)) rd_val[p % BANK_W] = pol[p];
            if (hit(addr, OFS_TYP, p)) rd_val[p % BANK_W] = typ[p];
            if (hit(addr, OFS_STS, p)) rd_val[p % BANK_W] = sts[p];
        end
    end

    // Register the read data and the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            ready <= 1'b0;
        end else begin
            rdata <= rd_en ? rd_val : '0;
            ready <= wr_en | rd_en;
        end
    end

    // R3: every request is acknowledged on the following cycle.
    a_r3_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en | rd_en) |=> ready);
endmodule

// File: rtl/gpio_bank_ctrl.sv
// Module: top of the banked GPIO controller.
// Connects the synchroniser, detector and register file, and forms the combined interrupt.
// Assumes the pins are sampled asynchronously and the register port is single-cycle.
module gpio_bank_ctrl #(
    parameter int NUM_PINS = 70,
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = gpio_pkg::BANK_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_ready,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq_out
);
    logic [NUM_PINS-1:0] lvl, sts, ien, pol, typ, clr;

    gpio_sync #(.W(NUM_PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl)
    );

    gpio_detect #(.W(NUM_PINS)) u_det (
        .clk(clk), .rst_n(rst_n), .lvl(lvl), .typ(typ), .pol(pol),
        .clr(clr), .sts(sts)
    );

    gpio_regs #(.W(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(bus_valid & bus_we), .rd_en(bus_valid & ~bus_we),
        .addr(bus_addr), .wdata(bus_wdata), .sts(sts),
        .oe(pin_oe), .drv(pin_out), .ien(ien), .pol(pol), .typ(typ),
        .clr(clr), .rdata(bus_rdata), .ready(bus_ready)
    );

    // Combine the enabled pending bits into one interrupt line.
    always_comb irq_out = |(sts & ien);

    // R3: ready is never high without a request on the previous cycle.
    a_r3_no_spurious_ready: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |-> $past(bus_valid));
endmodule

// File: tb/tb_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_bank_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic [69:0] pin_in = '0;
    logic [69:0] pin_out, pin_oe;
    logic        irq_out;
    int          n_run = 0, n_fail = 0;
    logic [31:0] r;

    always #2.5 clk = ~clk;

    gpio_bank_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_valid = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk); bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        rd(12'h014, r); chk("R2 oe word", r, 0);
        rd(12'h124, r); chk("R2 status word", r, 0);
        rd(12'h000, r); chk("R2 swap word", r, 0);
        chk("R2 pin_oe", {31'b0, pin_oe == '0}, 1);
        chk("R2 irq", {31'b0, irq_out}, 0);
    endtask

    task automatic t_plain_store();
        wr(12'h000, 32'hA5C3_0F19); rd(12'h000, r); chk("R12 swap", r, 32'hA5C3_0F19);
        wr(12'h004, 32'h1234_8765); rd(12'h004, r); chk("R12 ctrl", r, 32'h1234_8765);
    endtask

    task automatic t_oe_drive();
        wr(12'h018, 32'h0000_0010);
        chk("R4/R1 pin_oe bit 36", {31'b0, pin_oe == (70'd1 << 36)}, 1);
        wr(12'h024, 32'h8000_0001);
        chk("R5 pin_out bank0", pin_out[31:0], 32'h8000_0001);
        rd(12'h024, r); chk("R5 readback", r, 32'h8000_0001);
    endtask

    task automatic t_unimpl();
        wr(12'h02C, 32'hFFFF_FFFF);
        rd(12'h02C, r); chk("R6 bank2 pad read", r, 32'h0000_003F);
        chk("R6 pin_out top", {26'b0, pin_out[69:64]}, 32'h3F);
    endtask

    task automatic t_unmapped();
        rd(12'h020, r); chk("R3 gap read", r, 0);
        rd(12'h200, r); chk("R3 far read", r, 0);
        wr(12'h004, 32'h0);
        chk("R3 ready after write", {31'b0, bus_ready}, 1);
    endtask

    task automatic t_level_high();
        wr(12'h044, 32'h0000_0020);
        @(negedge clk); pin_in[5] = 1'b1;
        wait_cyc(2); chk("R7 not yet after two edges", {31'b0, irq_out}, 0);
        wait_cyc(1); chk("R7/R11 irq on third edge", {31'b0, irq_out}, 1);
        rd(12'h124, r); chk("R9 level high status", r, 32'h20);
        wr(12'h124, 32'h20); rd(12'h124, r); chk("R9 clear ignored while active", r, 32'h20);
        @(negedge clk); pin_in[5] = 1'b0;
        wait_cyc(4); wr(12'h124, 32'h20);
        rd(12'h124, r); chk("R10 cleared", r, 0);
        chk("R11 irq low after clear", {31'b0, irq_out}, 0);
    endtask

    task automatic t_level_low();
        wr(12'h108, 32'h0000_0100);
        wait_cyc(3); rd(12'h128, r); chk("R9 level low pin40", r, 32'h100);
        @(negedge clk); pin_in[40] = 1'b1;
        wait_cyc(4); wr(12'h128, 32'h100);
        rd(12'h128, r); chk("R9 level low cleared", r, 0);
    endtask

    task automatic t_edge_rise();
        wr(12'h11C, 32'h2);
        @(negedge clk); pin_in[65] = 1'b1;
        wait_cyc(3); rd(12'h12C, r); chk("R8 rising edge pin65", r, 32'h2);
        @(negedge clk); pin_in[65] = 1'b0;
        wait_cyc(4); rd(12'h12C, r); chk("R8 sticky after return", r, 32'h2);
        wr(12'h12C, 32'h0); rd(12'h12C, r); chk("R10 zero write keeps", r, 32'h2);
        wr(12'h12C, 32'h2); rd(12'h12C, r); chk("R10 one write clears", r, 0);
    endtask

    task automatic t_edge_fall();
        wr(12'h114, 32'h8); wr(12'h104, 32'h8);
        @(negedge clk); pin_in[3] = 1'b1;
        wait_cyc(4); rd(12'h124, r); chk("R8 rise ignored in falling mode", r, 0);
        @(negedge clk); pin_in[3] = 1'b0;
        wait_cyc(3); rd(12'h124, r); chk("R8 falling edge pin3", r, 32'h8);
    endtask

    task automatic t_irq_mask();
        chk("R11 masked status no irq", {31'b0, irq_out}, 0);
        wr(12'h044, 32'h8);
        chk("R11 enable raises irq", {31'b0, irq_out}, 1);
        wr(12'h124, 32'h8);
        chk("R11 clear drops irq", {31'b0, irq_out}, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        wait_cyc(4);
        rst_n = 1'b1;
        t_reset();
        t_plain_store();
        t_oe_drive();
        t_unimpl();
        t_unmapped();
        t_level_high();
        t_level_low();
        t_edge_rise();
        t_edge_fall();
        t_irq_mask();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule